// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes the destination part of one interrupt routing entry and works out which processor-side interrupt receivers get the interrupt. A request gives a destination identifier, an addressing-mode bit, a delivery-mode code, the vector and the trigger mode. Next to the request, the block reads three per-receiver tables: whether each receiver is present, its physical identifier and its logical identifier. From these it builds a candidate set and then selects the receivers. Fixed delivery grants every candidate. Lowest-priority delivery grants one candidate, chosen by a rotating pointer.

The result appears as a registered grant vector one clock after the request is sampled. The grant vector comes with the vector and trigger mode of the request. A delivery-mode code that the block does not handle produces a one-cycle unsupported pulse and no grant. A request whose candidate set is empty produces nothing at all.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical addressing (destLogical = 0), a destination of all ones (0xFF) makes every present receiver a candidate. Absent receivers are never granted in any mode.
- R2: In physical addressing with any other destination, the candidate set holds only the lowest-numbered present receiver whose physical identifier equals the destination. This is true even when several present receivers share that identifier.
- R3: In logical addressing (destLogical = 1), a destination of zero yields an empty candidate set.
- R4: In logical addressing with a non-zero destination, every present receiver whose logical identifier shares at least one set bit with the destination is a candidate.
- R5: A request with an empty candidate set gives grantValid = 0, grant = 0 and unsupported = 0 on the next cycle. It leaves the rotation pointer unchanged.
- R6: With delivery code 0 (fixed), the cycle after the request shows grantValid = 1 and grant equal to the whole candidate set. In the same cycle grantVector and grantTrig show the request's vector and trigger mode.
- R7: With delivery code 1 (lowest priority), the cycle after the request shows exactly one grant bit. That bit is the first candidate at or above the rotation pointer, wrapping past receiver 7 to receiver 0. The pointer is 0 after reset and moves to one past the granted receiver (modulo 8) after each such grant.
- R8: Delivery codes 2 to 7 with a non-empty candidate set give unsupported = 1 and grantValid = 0 on the next cycle, with grant = 0.
- R9: After reset, and on any cycle that follows a cycle without a request, grantValid, grant and unsupported are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is present this cycle |
| destId | input | 8 | Destination identifier |
| destLogical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| delivMode | input | 3 | Delivery code: 0 fixed, 1 lowest priority, others unsupported |
| vector | input | 8 | Interrupt vector carried to the grant |
| trigLevel | input | 1 | Trigger mode carried to the grant (1 = level) |
| tgtPresent | input | 8 | Per-receiver present bits |
| tgtPhysId | input | 64 | Physical identifiers, receiver i in bits [8i+7:8i] |
| tgtLogId | input | 64 | Logical identifiers, receiver i in bits [8i+7:8i] |
| grantValid | output | 1 | A grant is being issued this cycle |
| grant | output | 8 | Receivers granted, one bit per receiver |
| grantVector | output | 8 | Vector of the issued grant |
| grantTrig | output | 1 | Trigger mode of the issued grant |
| unsupported | output | 1 | Pulse: request used an unhandled delivery code |

## Verification
The assertions check a set of properties on every cycle:
- A lowest-priority grant is one-hot.
- A physical non-broadcast grant has a single bit.
- A logical zero destination never grants.
- Granted bits are always a subset of the present bits sampled with the request.
- The unsupported pulse never coincides with a grant.
- The rotation pointer only moves on a lowest-priority grant.

The bench's directed scenarios are needed for properties that no single-cycle property can show:
- Which receiver wins a tie on physical identifier.
- The exact logical match set.
- The rotation order across several requests, including the wrap and a skipped empty request.
- The forwarding of vector and trigger mode.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  // Delivery codes the resolver acts on; every other code is unsupported.
  localparam logic [2:0] MODE_FIXED  = 3'd0;
  localparam logic [2:0] MODE_ROTATE = 3'd1;

  // Strobes from control to datapath, at most one set per cycle.
  typedef struct packed {
    logic loadFixed;
    logic loadRotate;
    logic loadUnsup;
  } dpStrobe_t;

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irq_dest_pkg::*;
#(
  parameter int NT  = 8,
  parameter int IDW = 8,
  parameter int VW  = 8,
  parameter int PW  = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IDW-1:0]    destId,
  input  logic              destLogical,
  input  logic [VW-1:0]     vector,
  input  logic              trigLevel,
  input  logic [NT-1:0]     tgtPresent,
  input  logic [NT*IDW-1:0] tgtPhysId,
  input  logic [NT*IDW-1:0] tgtLogId,
  input  logic [PW-1:0]     rrPtr,
  input  dpStrobe_t         strb,
  output logic              candAny,
  output logic [PW-1:0]     pickIdx,
  output logic              grantValid,
  output logic [NT-1:0]     grant,
  output logic [VW-1:0]     grantVector,
  output logic              grantTrig,
  output logic              unsupported
);

  logic [NT-1:0] physHit;
  logic [NT-1:0] logHit;
  logic [NT-1:0] firstPhys;
  logic [NT-1:0] candMask;
  logic [NT-1:0] rotOneHot;
  logic          isBroadcast;
  logic          rotFound;

  // Per-receiver identifier comparison.
  for (genvar g = 0; g < NT; g++) begin : gTgt
    assign physHit[g] = tgtPresent[g] && (tgtPhysId[g*IDW +: IDW] == destId);
    assign logHit[g]  = tgtPresent[g] && (|(tgtLogId[g*IDW +: IDW] & destId));
  end

  assign isBroadcast = (destId == {IDW{1'b1}});
  // Isolate the lowest physical hit: search stops at the first match.
  assign firstPhys   = physHit & (~physHit + NT'(1));

  always_comb begin
    if (destLogical)
      candMask = (destId == '0) ? '0 : logHit;
    else if (isBroadcast)
      candMask = tgtPresent;
    else
      candMask = firstPhys;
  end

  assign candAny = |candMask;

  // Rotating search: first candidate at or above the pointer, wrapping.
  always_comb begin
    int idx;
    pickIdx  = '0;
    rotFound = 1'b0;
    for (int off = 0; off < NT; off++) begin
      idx = int'(rrPtr) + off;
      if (idx >= NT) idx = idx - NT;
      if (!rotFound && candMask[idx]) begin
        rotFound = 1'b1;
        pickIdx  = PW'(idx);
      end
    end
  end

  assign rotOneHot = NT'(1) << pickIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid  <= 1'b0;
      grant       <= '0;
      grantVector <= '0;
      grantTrig   <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      grantValid  <= strb.loadFixed | strb.loadRotate;
      unsupported <= strb.loadUnsup;
      if (strb.loadFixed)       grant <= candMask;
      else if (strb.loadRotate) grant <= rotOneHot;
      else                      grant <= '0;
      if (strb.loadFixed | strb.loadRotate) begin
        grantVector <= vector;
        grantTrig   <= trigLevel;
      end
    end
  end

  assert_rotate_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRotate |=> ($countones(grant) == 1));

  assert_phys_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadFixed && !destLogical && !isBroadcast) |=> ($countones(grant) == 1));

  assert_logical_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && destLogical && destId == '0) |=> !grantValid);

  assert_only_present_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadFixed || strb.loadRotate) |=> ((grant & ~$past(tgtPresent)) == '0));

  assert_valid_vs_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grant != '0));

  assert_unsup_no_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> !grantValid);

endmodule

// File: rtl/irq_dest_ctrl.sv
module irq_dest_ctrl
  import irq_dest_pkg::*;
#(
  parameter int NT = 8,
  parameter int PW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [2:0]    delivMode,
  input  logic          candAny,
  input  logic [PW-1:0] pickIdx,
  output dpStrobe_t     strb,
  output logic [PW-1:0] rrPtr
);

  logic deliver;

  assign deliver = reqValid && candAny;

  always_comb begin
    strb            = '0;
    strb.loadFixed  = deliver && (delivMode == MODE_FIXED);
    strb.loadRotate = deliver && (delivMode == MODE_ROTATE);
    strb.loadUnsup  = deliver && (delivMode != MODE_FIXED) && (delivMode != MODE_ROTATE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rrPtr <= '0;
    else if (strb.loadRotate)
      rrPtr <= (pickIdx == PW'(NT - 1)) ? '0 : pickIdx + 1'b1;
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadFixed, strb.loadRotate, strb.loadUnsup}));

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadRotate |=> $stable(rrPtr));

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int NT  = 8,
  parameter int IDW = 8,
  parameter int VW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IDW-1:0]    destId,
  input  logic              destLogical,
  input  logic [2:0]        delivMode,
  input  logic [VW-1:0]     vector,
  input  logic              trigLevel,
  input  logic [NT-1:0]     tgtPresent,
  input  logic [NT*IDW-1:0] tgtPhysId,
  input  logic [NT*IDW-1:0] tgtLogId,
  output logic              grantValid,
  output logic [NT-1:0]     grant,
  output logic [VW-1:0]     grantVector,
  output logic              grantTrig,
  output logic              unsupported
);

  localparam int PW = (NT > 1) ? $clog2(NT) : 1;

  dpStrobe_t     strb;
  logic          candAny;
  logic [PW-1:0] pickIdx;
  logic [PW-1:0] rrPtr;

  irq_dest_ctrl #(.NT(NT), .PW(PW)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .delivMode(delivMode),
    .candAny(candAny), .pickIdx(pickIdx), .strb(strb), .rrPtr(rrPtr)
  );

  irq_dest_match #(.NT(NT), .IDW(IDW), .VW(VW), .PW(PW)) match_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .destId(destId),
    .destLogical(destLogical), .vector(vector), .trigLevel(trigLevel),
    .tgtPresent(tgtPresent), .tgtPhysId(tgtPhysId), .tgtLogId(tgtLogId),
    .rrPtr(rrPtr), .strb(strb), .candAny(candAny), .pickIdx(pickIdx),
    .grantValid(grantValid), .grant(grant), .grantVector(grantVector),
    .grantTrig(grantTrig), .unsupported(unsupported)
  );

endmodule

// File: tb/irq_dest_resolver_tb_top.sv
module irq_dest_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  destId = '0;
  logic        destLogical = 1'b0;
  logic [2:0]  delivMode = '0;
  logic [7:0]  vector = '0;
  logic        trigLevel = 1'b0;
  logic [7:0]  tgtPresent = '0;
  logic [63:0] tgtPhysId;
  logic [63:0] tgtLogId;
  logic        grantValid;
  logic [7:0]  grant;
  logic [7:0]  grantVector;
  logic        grantTrig;
  logic        unsupported;

  logic [7:0] physTab [8];
  logic [7:0] logTab [8];
  int         total = 0;
  int         bad = 0;
  int         rrModel = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      tgtPhysId[i*8 +: 8] = physTab[i];
      tgtLogId[i*8 +: 8]  = logTab[i];
    end
  end

  irq_dest_resolver dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .destId(destId),
    .destLogical(destLogical), .delivMode(delivMode), .vector(vector),
    .trigLevel(trigLevel), .tgtPresent(tgtPresent), .tgtPhysId(tgtPhysId),
    .tgtLogId(tgtLogId), .grantValid(grantValid), .grant(grant),
    .grantVector(grantVector), .grantTrig(grantTrig), .unsupported(unsupported)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Candidate set computed from the requirement text (R1-style rules).
  function automatic logic [7:0] candModel(input logic [7:0] d, input logic lg);
    logic [7:0] m = '0;
    if (lg) begin
      if (d != 0)
        for (int i = 0; i < 8; i++)
          if (tgtPresent[i] && ((logTab[i] & d) != 0)) m[i] = 1'b1;
    end else if (d == 8'hFF) begin
      m = tgtPresent;
    end else begin
      for (int i = 0; i < 8; i++)
        if (m == 0 && tgtPresent[i] && physTab[i] == d) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Drive one request at a falling edge; outputs are read one cycle later.
  task automatic fire(input logic [7:0] d, input logic lg, input logic [2:0] md,
                      input logic [7:0] vec, input logic trg);
    @(negedge clk);
    destId = d; destLogical = lg; delivMode = md; vector = vec; trigLevel = trg;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic test_reset;
    chk("R9 reset grantValid", 32'(grantValid), 0);
    chk("R9 reset grant", 32'(grant), 0);
    chk("R9 reset unsupported", 32'(unsupported), 0);
  endtask

  task automatic test_broadcast;
    tgtPresent = 8'b1011_0110;
    fire(8'hFF, 1'b0, 3'd0, 8'h41, 1'b0);
    chk("R1 broadcast grant", 32'(grant), 32'h0000_00B6);
    chk("R1 broadcast valid", 32'(grantValid), 1);
    @(negedge clk);
    chk("R9 idle after grant", 32'(grantValid), 0);
  endtask

  task automatic test_physical;
    tgtPresent = 8'hFF;
    fire(8'h33, 1'b0, 3'd0, 8'h20, 1'b0);
    chk("R2 first of duplicates", 32'(grant), 32'h04);
    tgtPresent = 8'b1111_1011;
    fire(8'h33, 1'b0, 3'd0, 8'h20, 1'b0);
    chk("R2 skip absent", 32'(grant), 32'h20);
    chk("R2 model agrees", 32'(grant), 32'(candModel(8'h33, 1'b0)));
  endtask

  task automatic test_logical;
    tgtPresent = 8'b1111_1110;
    fire(8'h00, 1'b1, 3'd0, 8'h50, 1'b0);
    chk("R3 zero dest valid", 32'(grantValid), 0);
    chk("R3 zero dest grant", 32'(grant), 0);
    fire(8'h0D, 1'b1, 3'd0, 8'h51, 1'b1);
    chk("R4 logical set", 32'(grant), 32'(candModel(8'h0D, 1'b1)));
    chk("R4 logical set literal", 32'(grant), 32'h0C);
  endtask

  task automatic test_fixed_fields;
    tgtPresent = 8'hFF;
    fire(8'h92, 1'b1, 3'd0, 8'hA7, 1'b1);
    chk("R6 fixed grant", 32'(grant), 32'(candModel(8'h92, 1'b1)));
    chk("R6 vector", 32'(grantVector), 32'hA7);
    chk("R6 trigger", 32'(grantTrig), 1);
  endtask

  task automatic test_empty;
    tgtPresent = 8'hFF;
    fire(8'h77, 1'b0, 3'd0, 8'h10, 1'b0);
    chk("R5 empty valid", 32'(grantValid), 0);
    chk("R5 empty grant", 32'(grant), 0);
    fire(8'h77, 1'b0, 3'd5, 8'h10, 1'b0);
    chk("R5 empty unsupported", 32'(unsupported), 0);
  endtask

  task automatic rotate_once(input logic [7:0] d, input string tag);
    logic [7:0] m;
    logic [7:0] exp = '0;
    int pick = -1;
    m = candModel(d, 1'b1);
    for (int off = 0; off < 8; off++) begin
      int idx = (rrModel + off) % 8;
      if (pick < 0 && m[idx]) pick = idx;
    end
    if (pick >= 0) begin
      exp[pick] = 1'b1;
      rrModel = (pick + 1) % 8;
    end
    fire(d, 1'b1, 3'd1, 8'h33, 1'b0);
    chk(tag, 32'(grant), 32'(exp));
  endtask

  task automatic test_rotate;
    tgtPresent = 8'hFF;
    // Candidates 1,4,6 from pointer 0: expect 1, 4, 6, then wrap to 1.
    rotate_once(8'h52, "R7 rotate first");
    chk("R7 rotate literal", 32'(grant), 32'h02);
    rotate_once(8'h52, "R7 rotate second");
    rotate_once(8'h52, "R7 rotate third");
    chk("R7 rotate third literal", 32'(grant), 32'h40);
    rotate_once(8'h52, "R7 rotate wrap");
    chk("R7 wrap literal", 32'(grant), 32'h02);
    fire(8'h00, 1'b1, 3'd1, 8'h33, 1'b0);
    chk("R5 empty rotate", 32'(grantValid), 0);
    rotate_once(8'h52, "R5 pointer held");
    chk("R5 pointer held literal", 32'(grant), 32'h10);
    rotate_once(8'h80, "R7 single candidate");
    rotate_once(8'h52, "R7 after wrap to zero");
  endtask

  task automatic test_unsupported;
    tgtPresent = 8'hFF;
    fire(8'hFF, 1'b0, 3'd2, 8'h01, 1'b0);
    chk("R8 code2 flag", 32'(unsupported), 1);
    chk("R8 code2 no grant", 32'(grantValid), 0);
    fire(8'h01, 1'b1, 3'd7, 8'h01, 1'b0);
    chk("R8 code7 flag", 32'(unsupported), 1);
    chk("R8 code7 grant", 32'(grant), 0);
    @(negedge clk);
    chk("R9 flag drops", 32'(unsupported), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      physTab[i] = 8'h10 + 8'(i);
      logTab[i]  = 8'(1 << i);
    end
    physTab[2] = 8'h33;
    physTab[5] = 8'h33;
    logTab[3]  = 8'h0C;
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_broadcast();
    test_physical();
    test_logical();
    test_fixed_fields();
    test_empty();
    test_rotate();
    test_unsupported();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule